// File: doc/BRIEF.md
# Dual-Cycle-Deselect Output Control for a Synchronous SRAM

This block drives the data bus of a synchronous SRAM. Chip enables, address strobes and the write control are sampled on each rising clock edge and decoded into one of three commands: read, write or deselect. Every command, a deselect included, travels the same output pipeline, so the bus stops being driven exactly as many edges after a deselect as a read would take to show its data. The array is behavioural and outside the block: it presents the word for the current access on `rd_data`, and the block returns that word on `dq_out` together with a drive-enable that stands for the tri-state control.

A static mode input selects pipeline operation, in which an output register adds one cycle (first word on the third edge of a 3-1-1-1 burst), or flow-through operation, in which the register is bypassed (2-1-1-1). A write leaves an undriven slot in the pipeline. An asynchronous active-low output enable can force the bus off at any moment, whatever the pipeline holds.

The command decoder is a three-state machine, `CMD_DESEL`, `CMD_READ` and `CMD_WRITE`. Its transitions are: strobe with any enable inactive (to `CMD_DESEL`); host strobe with all enables active (to `CMD_READ`); controller strobe with all enables active (to `CMD_READ` or `CMD_WRITE` by `wr_n`); no strobe from `CMD_DESEL` (stay); no strobe from `CMD_READ` or `CMD_WRITE` (continue, to `CMD_READ` or `CMD_WRITE` by `wr_n`); synchronous reset (to `CMD_DESEL`). The output slot is a two-state machine, `SLOT_IDLE` and `SLOT_DATA`: it loads `SLOT_DATA` when the decoder holds `CMD_READ` and `SLOT_IDLE` otherwise, and reset forces `SLOT_IDLE`.

Top module: `dcd_out_ctrl`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) places both the decoder and the output slot in their idle states, so that after that edge `dq_drive` is 0 and `dq_out` is 0.
- R2: The device counts as selected only when `ce_a_n` is 0, `ce_b` is 1 and `ce_c_n` is 0 at the edge; a strobe seen while any one of the three is inactive decodes as a deselect.
- R3: A host strobe (`stb_host_n` low, which has priority over the controller strobe) always starts a read and ignores `wr_n`; a controller strobe (`stb_ctrl_n` low) starts a write when `wr_n` is 0 and a read when it is 1.
- R4: An edge with no strobe keeps a deselected device deselected, whatever `wr_n` is; otherwise it continues the access, as a write when `wr_n` is 0 and as a read when it is 1.
- R5: In flow-through mode (`flow_mode` = 1) a read sampled at edge N drives the bus right after edge N with `rd_data` passed straight through.
- R6: In pipeline mode (`flow_mode` = 0) a read sampled at edge N drives the bus after edge N+1 with the `rd_data` word captured at edge N+1.
- R7: A deselect sampled at edge N turns the drive off after edge N in flow-through mode; in pipeline mode the drive of the preceding access is held through the following cycle and falls just after edge N+1.
- R8: A write cycle leaves a bubble: the slot it occupies (after edge N in flow-through, after edge N+1 in pipeline mode) is not driven.
- R9: While `oe_n` is 1 the bus is not driven, with no clock edge needed; when `oe_n` returns to 0 the pipeline's drive state reappears at once.
- R10: `dq_out` is all zeros whenever `dq_drive` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| ce_a_n | input | 1 | Chip enable A, active low |
| ce_b | input | 1 | Chip enable B, active high |
| ce_c_n | input | 1 | Chip enable C, active low |
| stb_host_n | input | 1 | Host address strobe, active low, always starts a read |
| stb_ctrl_n | input | 1 | Controller address strobe, active low |
| wr_n | input | 1 | Write request, active low |
| flow_mode | input | 1 | 1 = flow-through, 0 = pipeline |
| oe_n | input | 1 | Asynchronous output enable, active low |
| rd_data | input | DATA_W | Word read from the array for the current access |
| dq_out | output | DATA_W | Data presented on the bus |
| dq_drive | output | 1 | Bus drive-enable (tri-state control) |

## Verification
The assertions watch on every cycle that the output enable forces the drive off, that an undriven bus carries zeros, that reset leaves the bus idle, and that reads, writes and deselects change the drive on the exact edge each mode calls for. Only the bench's scenarios can show the data values themselves, the continuation of an access with no strobe, the host strobe overriding `wr_n`, and the drive returning when the output enable comes back mid-cycle; a cycle-accurate reference model compares drive and data after every edge across both modes, each enable dropped on its own, and a reset in the middle of a burst.

// File: rtl/dcd_pkg.sv
package dcd_pkg;

    // Command held in the first pipeline stage
    typedef enum logic [1:0] {
        CMD_DESEL = 2'd0,
        CMD_READ  = 2'd1,
        CMD_WRITE = 2'd2
    } cmd_e;

    // State of the output register slot
    typedef enum logic {
        SLOT_IDLE = 1'b0,
        SLOT_DATA = 1'b1
    } slot_e;

endpackage

// File: rtl/dcd_cmd_decode.sv
module dcd_cmd_decode
    import dcd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ce_a_n,
    input  logic ce_b,
    input  logic ce_c_n,
    input  logic stb_host_n,
    input  logic stb_ctrl_n,
    input  logic wr_n,
    output cmd_e cmd_q
);

    logic selected;
    logic strobe;
    cmd_e cmd_d;

    assign selected = ~ce_a_n & ce_b & ~ce_c_n;
    assign strobe   = ~stb_host_n | ~stb_ctrl_n;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q <= CMD_DESEL;
        end else begin
            cmd_q <= cmd_d;
        end
    end

    // Next-state decode
    always_comb begin
        cmd_d = cmd_q;
        if (strobe) begin
            if (!selected) begin
                cmd_d = CMD_DESEL;
            end else if (!stb_host_n) begin
                cmd_d = CMD_READ;
            end else begin
                cmd_d = wr_n ? CMD_READ : CMD_WRITE;
            end
        end else begin
            unique case (cmd_q)
                CMD_DESEL: cmd_d = CMD_DESEL;
                CMD_READ,
                CMD_WRITE: cmd_d = wr_n ? CMD_READ : CMD_WRITE;
                default:   cmd_d = CMD_DESEL;
            endcase
        end
    end

endmodule

// File: rtl/dcd_out_stage.sv
module dcd_out_stage
    import dcd_pkg::*;
#(
    parameter int DATA_W = 18
) (
    input  logic              clk,
    input  logic              rst,
    input  cmd_e              cmd_q,
    input  logic [DATA_W-1:0] rd_data,
    input  logic              flow_mode,
    input  logic              oe_n,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_drive
);

    slot_e             slot_q;
    logic [DATA_W-1:0] data_q;
    logic              slot_busy;

    // Output register: the second pipeline stage
    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q <= SLOT_IDLE;
            data_q <= '0;
        end else begin
            unique case (cmd_q)
                CMD_READ: begin
                    slot_q <= SLOT_DATA;
                    data_q <= rd_data;
                end
                CMD_DESEL,
                CMD_WRITE: begin
                    slot_q <= SLOT_IDLE;
                    data_q <= '0;
                end
                default: begin
                    slot_q <= SLOT_IDLE;
                    data_q <= '0;
                end
            endcase
        end
    end

    // Output drive: register bypassed in flow-through mode
    always_comb begin
        if (flow_mode) begin
            slot_busy = (cmd_q == CMD_READ);
        end else begin
            slot_busy = (slot_q == SLOT_DATA);
        end
        dq_drive = slot_busy & ~oe_n;
        if (!dq_drive) begin
            dq_out = '0;
        end else if (flow_mode) begin
            dq_out = rd_data;
        end else begin
            dq_out = data_q;
        end
    end

endmodule

// File: rtl/dcd_out_ctrl.sv
module dcd_out_ctrl
    import dcd_pkg::*;
#(
    parameter int DATA_W = 18
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_a_n,
    input  logic              ce_b,
    input  logic              ce_c_n,
    input  logic              stb_host_n,
    input  logic              stb_ctrl_n,
    input  logic              wr_n,
    input  logic              flow_mode,
    input  logic              oe_n,
    input  logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_drive
);

    cmd_e cmd_q;

    dcd_cmd_decode u_decode (
        .clk        (clk),
        .rst        (rst),
        .ce_a_n     (ce_a_n),
        .ce_b       (ce_b),
        .ce_c_n     (ce_c_n),
        .stb_host_n (stb_host_n),
        .stb_ctrl_n (stb_ctrl_n),
        .wr_n       (wr_n),
        .cmd_q      (cmd_q)
    );

    dcd_out_stage #(.DATA_W(DATA_W)) u_stage (
        .clk       (clk),
        .rst       (rst),
        .cmd_q     (cmd_q),
        .rd_data   (rd_data),
        .flow_mode (flow_mode),
        .oe_n      (oe_n),
        .dq_out    (dq_out),
        .dq_drive  (dq_drive)
    );

endmodule

// File: rtl/dcd_out_chk.sv
module dcd_out_chk #(
    parameter int DATA_W = 18
) (
    input logic              clk,
    input logic              rst,
    input logic              ce_a_n,
    input logic              ce_b,
    input logic              ce_c_n,
    input logic              stb_host_n,
    input logic              stb_ctrl_n,
    input logic              wr_n,
    input logic              flow_mode,
    input logic              oe_n,
    input logic [DATA_W-1:0] dq_out,
    input logic              dq_drive
);

    logic sel_all;
    logic any_stb;
    logic rst_seen;

    assign sel_all = ~ce_a_n & ce_b & ~ce_c_n;
    assign any_stb = ~stb_host_n | ~stb_ctrl_n;

    always_ff @(posedge clk) begin
        rst_seen <= rst;
    end

    // R1: the cycle after a reset edge the bus is idle
    always_comb begin
        if (rst_seen === 1'b1) begin
            assert_reset_idle_R1: assert (dq_drive == 1'b0);
        end
    end

    // R9: output enable high forces the drive off
    always_comb begin
        if (oe_n === 1'b1) begin
            assert_oe_forces_off_R9: assert (dq_drive == 1'b0);
        end
    end

    // R10: undriven bus carries zeros
    always_comb begin
        if (dq_drive === 1'b0) begin
            assert_idle_bus_zero_R10: assert (dq_out == '0);
        end
    end

    // R7: flow-through deselect turns the drive off after the same edge
    assert_flow_desel_off_R7: assert property (@(posedge clk) disable iff (rst)
        (flow_mode && any_stb && !sel_all) |=> (!flow_mode || !dq_drive));

    // R7: pipeline deselect turns the drive off after the following edge
    assert_pipe_desel_off_R7: assert property (@(posedge clk) disable iff (rst)
        (!flow_mode && any_stb && !sel_all) |=> ##1 (flow_mode || !dq_drive));

    // R3, R5: host strobe read drives right after the edge in flow-through
    assert_flow_host_read_R5: assert property (@(posedge clk) disable iff (rst)
        (flow_mode && !stb_host_n && sel_all) |=> (!flow_mode || oe_n || dq_drive));

    // R3, R6: host strobe read drives one edge later in pipeline mode
    assert_pipe_host_read_R6: assert property (@(posedge clk) disable iff (rst)
        (!flow_mode && !stb_host_n && sel_all) |=> ##1 (flow_mode || oe_n || dq_drive));

    // R8: a controller-strobed write leaves its flow-through slot undriven
    assert_write_bubble_R8: assert property (@(posedge clk) disable iff (rst)
        (flow_mode && sel_all && stb_host_n && !stb_ctrl_n && !wr_n) |=> (!flow_mode || !dq_drive));

endmodule

bind dcd_out_ctrl dcd_out_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .ce_a_n     (ce_a_n),
    .ce_b       (ce_b),
    .ce_c_n     (ce_c_n),
    .stb_host_n (stb_host_n),
    .stb_ctrl_n (stb_ctrl_n),
    .wr_n       (wr_n),
    .flow_mode  (flow_mode),
    .oe_n       (oe_n),
    .dq_out     (dq_out),
    .dq_drive   (dq_drive)
);

// File: tb/sim_dcd_out_ctrl.sv
module sim_dcd_out_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int W = 18;
    localparam int K_DESEL = 0;
    localparam int K_READ  = 1;
    localparam int K_WRITE = 2;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         ce_a_n = 1'b0, ce_b = 1'b1, ce_c_n = 1'b0;
    logic         stb_host_n = 1'b1, stb_ctrl_n = 1'b1, wr_n = 1'b1;
    logic         flow_mode = 1'b1, oe_n = 1'b0;
    logic [W-1:0] rd_data = '0;
    logic [W-1:0] dq_out;
    logic         dq_drive;

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    // Reference model state
    int           m_cur = K_DESEL;
    int           m_prev = K_DESEL;
    logic [W-1:0] m_cap = '0;

    dcd_out_ctrl #(.DATA_W(W)) u0 (
        .clk(clk), .rst(rst), .ce_a_n(ce_a_n), .ce_b(ce_b), .ce_c_n(ce_c_n),
        .stb_host_n(stb_host_n), .stb_ctrl_n(stb_ctrl_n), .wr_n(wr_n),
        .flow_mode(flow_mode), .oe_n(oe_n), .rd_data(rd_data),
        .dq_out(dq_out), .dq_drive(dq_drive)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    initial begin
        #(CLK_PERIOD * 100000);
        failures++;
        $display("FAIL watchdog (all R) actual=running expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    function automatic int next_kind();
        bit sel;
        sel = !ce_a_n && ce_b && !ce_c_n;
        if (!stb_host_n) return sel ? K_READ : K_DESEL;
        if (!stb_ctrl_n) return sel ? (wr_n ? K_READ : K_WRITE) : K_DESEL;
        if (m_cur == K_DESEL) return K_DESEL;
        return wr_n ? K_READ : K_WRITE;
    endfunction

    task automatic check_bit(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s cycle %0d drive actual=%b expected=%b", tag, cyc, act, exp);
        end
    endtask

    task automatic check_word(string tag, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s cycle %0d data actual=%h expected=%h", tag, cyc, act, exp);
        end
    endtask

    function automatic logic exp_drive();
        return (flow_mode ? (m_cur == K_READ) : (m_prev == K_READ)) && !oe_n;
    endfunction

    // One clock: update the model at the edge, compare a quarter period later,
    // then change rd_data at the falling edge.
    task automatic tick(string tag);
        int nk;
        logic e_drv;
        logic [W-1:0] e_dat;
        @(posedge clk);
        cyc++;
        if (rst) begin
            m_cur = K_DESEL; m_prev = K_DESEL; m_cap = '0;
        end else begin
            nk = next_kind();
            m_prev = m_cur;
            m_cap = rd_data;
            m_cur = nk;
        end
        #(CLK_PERIOD/4);
        e_drv = exp_drive();
        e_dat = e_drv ? (flow_mode ? rd_data : m_cap) : '0;
        check_bit(tag, dq_drive, e_drv);
        check_word(tag, dq_out, e_dat);
        @(negedge clk);
        rd_data = W'(cyc * 32'h1357 + 32'h0A5);
    endtask

    task automatic quiet();
        ce_a_n = 1'b0; ce_b = 1'b1; ce_c_n = 1'b0;
        stb_host_n = 1'b1; stb_ctrl_n = 1'b1; wr_n = 1'b1;
    endtask

    task automatic run_mode(logic fm, string tg);
        flow_mode = fm;
        quiet();
        tick({tg, " R4 idle"});
        // host strobe read, wr_n low ignored (R3), then burst continues (R4)
        stb_host_n = 1'b0; wr_n = 1'b0;
        tick({tg, " R3 host read"});
        quiet();
        tick({tg, " R4 continue read R5 R6"});
        tick({tg, " R4 continue read R5 R6"});
        // deselect by ce_b (R2, R7)
        stb_host_n = 1'b0; ce_b = 1'b0;
        tick({tg, " R2 R7 deselect"});
        quiet(); wr_n = 1'b0;
        tick({tg, " R4 stays deselected R7"});
        tick({tg, " R4 stays deselected"});
        // controller strobe write (R3, R8), continue write, then read
        stb_ctrl_n = 1'b0; wr_n = 1'b0;
        tick({tg, " R3 R8 write"});
        stb_ctrl_n = 1'b1;
        tick({tg, " R4 R8 continue write"});
        wr_n = 1'b1;
        tick({tg, " R4 read after write"});
        tick({tg, " R4 R8 read"});
        // each enable inactive on its own (R2)
        stb_ctrl_n = 1'b0; ce_a_n = 1'b1;
        tick({tg, " R2 ce_a inactive"});
        quiet(); stb_host_n = 1'b0;
        tick({tg, " R2 read"});
        quiet(); stb_ctrl_n = 1'b0; ce_c_n = 1'b1;
        tick({tg, " R2 ce_c inactive"});
        quiet();
        tick({tg, " R2 R7 drain"});
        tick({tg, " R2 drain"});
    endtask

    initial begin
        // R1: reset
        tick("R1 reset");
        tick("R1 reset");
        check_bit("R1 reset drive", dq_drive, 1'b0);
        check_word("R1 reset data", dq_out, '0);
        rst = 1'b0;

        run_mode(1'b1, "flow");
        run_mode(1'b0, "pipe");

        // R7: explicit fall cycle of the drive, pipeline mode
        flow_mode = 1'b0; quiet(); stb_host_n = 1'b0;
        tick("R6 setup read");
        quiet();
        tick("R6 read data");
        check_bit("R6 pipe read driven", dq_drive, 1'b1);
        stb_host_n = 1'b0; ce_c_n = 1'b1;
        tick("R7 pipe deselect edge");
        check_bit("R7 pipe still driven after deselect edge", dq_drive, 1'b1);
        quiet();
        tick("R7 pipe second edge");
        check_bit("R7 pipe off after second edge", dq_drive, 1'b0);

        // R7: explicit fall cycle, flow-through mode
        flow_mode = 1'b1; stb_host_n = 1'b0;
        tick("R5 flow read");
        check_bit("R5 flow read driven", dq_drive, 1'b1);
        stb_host_n = 1'b0; ce_a_n = 1'b1;
        tick("R7 flow deselect edge");
        check_bit("R7 flow off after deselect edge", dq_drive, 1'b0);

        // R9: asynchronous output enable in the middle of a read
        quiet(); stb_host_n = 1'b0;
        tick("R9 setup");
        quiet();
        tick("R9 setup");
        #(CLK_PERIOD/4);
        oe_n = 1'b1;
        #1;
        check_bit("R9 oe_n high forces off", dq_drive, 1'b0);
        check_word("R10 zero while off", dq_out, '0);
        oe_n = 1'b0;
        #1;
        check_bit("R9 oe_n low restores", dq_drive, 1'b1);
        check_word("R9 data restored", dq_out, rd_data);
        oe_n = 1'b1;
        tick("R9 oe_n held high");
        oe_n = 1'b0;

        // R1: reset in the middle of a pipeline burst
        flow_mode = 1'b0; stb_host_n = 1'b0;
        tick("R1 burst start");
        quiet();
        tick("R1 burst");
        rst = 1'b1;
        tick("R1 mid-burst reset");
        check_bit("R1 off after mid-burst reset", dq_drive, 1'b0);
        rst = 1'b0;
        tick("R1 R4 after reset stays deselected");

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule